// File: doc/BRIEF.md
# Whole-Frame Receive Slip Buffer

This block is an elastic store for a received E1 timeslot stream. Words arrive with a write enable paced by the recovered line rate. They leave with a read enable paced by the local rate. The store holds a whole number of 32-word frames. When the two rates drift apart far enough, the block corrects the drift by a full frame. If the writer has run too far ahead, it skips a frame on the output. If the reader has caught up with the writer, it plays the previous frame a second time. The output therefore always stays frame-aligned.

Every slip is classified by direction. A separate flag records whether the local side was the slow one, which is the dropped-frame case, or the fast one, which is the repeated-frame case. A sticky slip alarm is set only while the receive side reports frame lock. That alarm drives an interrupt through a mask bit, and the mask comes out of reset set, so the interrupt is blocked. The direction flag never drives the interrupt. Both rates are enables within one clock domain.

Top module: `frame_slip_buffer`

## Requirements
- R1: After reset, rdData is 0, skipFlag is 0, slowLocal is 0 and irq is 0.
- R2: Each cycle with wrEn high stores wrData at the next write position. A read (rdEn high) presents a word on rdData one clock later. Without a slip, words come out in the order they were written.
- R3: A slip is considered only on a read taken while the read position is a multiple of 32. The fill level is (write position − read position) mod 64. A fill of 8 through 56 inclusive, or any read off a frame boundary, gives no slip.
- R4: A read at a frame boundary with a fill above 56 drops one frame. The word delivered is the one written 32 positions after the word that would have been read. Reading continues in order from there.
- R5: A read at a frame boundary with a fill below 8 repeats one frame. The word delivered is the one 32 positions earlier, and the whole previous frame of 32 words is output again.
- R6: Any slip sets skipFlag while frameLocked is 1. A slip taken while frameLocked is 0 leaves skipFlag unchanged. skipFlag stays set until it is cleared.
- R7: A one-cycle skipClr pulse clears skipFlag.
- R8: slowLocal becomes 1 after a drop and 0 after a repeat, whatever the state of frameLocked. It never affects irq.
- R9: The skip mask resets to 1. maskWe loads it from maskIn. irq is 1 exactly when skipFlag is 1 and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameLocked | input | 1 | Receive frame alignment present; qualifies the slip alarm |
| wrEn | input | 1 | Write strobe at remote rate |
| wrData | input | 8 | Received timeslot word |
| rdEn | input | 1 | Read strobe at local rate |
| rdData | output | 8 | Word read out, valid the cycle after rdEn |
| skipClr | input | 1 | Clear pulse for skipFlag |
| maskWe | input | 1 | Load strobe for the skip mask |
| maskIn | input | 1 | New skip mask value (1 = masked) |
| skipFlag | output | 1 | Sticky slip alarm |
| slowLocal | output | 1 | Direction of last slip: 1 after a drop, 0 after a repeat |
| irq | output | 1 | Interrupt: unmasked sticky alarms |

## Verification
The bench builds the block with its defaults: 8-bit words, 32-word frames, two frames of storage, a drop limit of 56 and a repeat limit of 8. With only 64 locations, every fill level is reached by a short burst of writes. This covers a fill exactly on each limit, one word past each limit, and fills that pass the repeat limit between frame boundaries. Each burst is written with a running count as its data, so the bench can tell a dropped or repeated frame from the values alone.

// File: rtl/slip_pkg.sv
`timescale 1ns/1ps
package slip_pkg;
  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_DROP   = 2'd1,
    SLIP_REPEAT = 2'd2
  } slipKind_e;

  typedef struct packed {
    logic      wrStb;
    logic      rdStb;
    slipKind_e slip;
  } dpCtrl_t;
endpackage

// File: rtl/slip_datapath.sv
`timescale 1ns/1ps
module slip_datapath
  import slip_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int FRAME_WORDS = 32,
  parameter int FRAMES      = 2,
  localparam int DEPTH      = FRAME_WORDS * FRAMES,
  localparam int PTR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr
);
  localparam logic [PTR_W-1:0] FRAME_OFF = PTR_W'(FRAME_WORDS);
  localparam logic [PTR_W-1:0] ONE       = PTR_W'(1);

  logic [WORD_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  rdAddr;

  always_comb begin
    unique case (dpCtrl.slip)
      SLIP_DROP:   rdAddr = rdPtr + FRAME_OFF;
      SLIP_REPEAT: rdAddr = rdPtr - FRAME_OFF;
      default:     rdAddr = rdPtr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (dpCtrl.wrStb) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (dpCtrl.wrStb) wrPtr <= wrPtr + ONE;
      if (dpCtrl.rdStb) begin
        rdData <= store[rdAddr];
        rdPtr  <= rdAddr + ONE;
      end
    end
  end

  // R2
  rd_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.rdStb |=> $stable(rdPtr));

  // R2
  wr_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.wrStb |=> $stable(wrPtr));
endmodule

// File: rtl/slip_ctrl.sv
`timescale 1ns/1ps
module slip_ctrl
  import slip_pkg::*;
#(
  parameter int FRAME_WORDS = 32,
  parameter int FRAMES      = 2,
  parameter int DROP_THRESH = 56,
  parameter int REP_THRESH  = 8,
  localparam int DEPTH      = FRAME_WORDS * FRAMES,
  localparam int PTR_W      = $clog2(DEPTH),
  localparam int OFF_W      = $clog2(FRAME_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             frameLocked,
  input  logic             skipClr,
  input  logic             maskWe,
  input  logic             maskIn,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  output dpCtrl_t          dpCtrl,
  output logic             skipFlag,
  output logic             slowLocal,
  output logic             irq
);
  localparam logic [PTR_W-1:0] DROP_LIM = PTR_W'(DROP_THRESH);
  localparam logic [PTR_W-1:0] REP_LIM  = PTR_W'(REP_THRESH);

  logic [PTR_W-1:0] fill;
  logic             atBoundary;
  slipKind_e        slipNow;
  logic             skipMask;

  assign fill       = wrPtr - rdPtr;
  assign atBoundary = (rdPtr[OFF_W-1:0] == '0);

  always_comb begin
    slipNow = SLIP_NONE;
    if (rdEn && atBoundary) begin
      if (fill > DROP_LIM)     slipNow = SLIP_DROP;
      else if (fill < REP_LIM) slipNow = SLIP_REPEAT;
    end
  end

  assign dpCtrl = '{wrStb: wrEn, rdStb: rdEn, slip: slipNow};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      skipFlag  <= 1'b0;
      slowLocal <= 1'b0;
      skipMask  <= 1'b1;
    end else begin
      if (maskWe) skipMask <= maskIn;
      if (slipNow != SLIP_NONE) slowLocal <= (slipNow == SLIP_DROP);
      if ((slipNow != SLIP_NONE) && frameLocked) skipFlag <= 1'b1;
      else if (skipClr)                          skipFlag <= 1'b0;
    end
  end

  assign irq = skipFlag & ~skipMask;

  // R6
  skip_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slipNow != SLIP_NONE && frameLocked) |=> skipFlag);

  // R7
  skip_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (skipClr && slipNow == SLIP_NONE) |=> !skipFlag);

  // R8
  slc_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slipNow == SLIP_DROP) |=> slowLocal);

  // R8
  slc_rep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slipNow == SLIP_REPEAT) |=> !slowLocal);

  // R3
  slip_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.slip != SLIP_NONE) |-> (rdEn && rdPtr[OFF_W-1:0] == '0));
endmodule

// File: rtl/frame_slip_buffer.sv
`timescale 1ns/1ps
module frame_slip_buffer
  import slip_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int FRAME_WORDS = 32,
  parameter int FRAMES      = 2,
  parameter int DROP_THRESH = 56,
  parameter int REP_THRESH  = 8,
  localparam int DEPTH      = FRAME_WORDS * FRAMES,
  localparam int PTR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameLocked,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  input  logic              skipClr,
  input  logic              maskWe,
  input  logic              maskIn,
  output logic              skipFlag,
  output logic              slowLocal,
  output logic              irq
);
  dpCtrl_t          dpCtrl;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  slip_ctrl #(
    .FRAME_WORDS(FRAME_WORDS),
    .FRAMES     (FRAMES),
    .DROP_THRESH(DROP_THRESH),
    .REP_THRESH (REP_THRESH)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .frameLocked(frameLocked),
    .skipClr    (skipClr),
    .maskWe     (maskWe),
    .maskIn     (maskIn),
    .wrPtr      (wrPtr),
    .rdPtr      (rdPtr),
    .dpCtrl     (dpCtrl),
    .skipFlag   (skipFlag),
    .slowLocal  (slowLocal),
    .irq        (irq)
  );

  slip_datapath #(
    .WORD_W     (WORD_W),
    .FRAME_WORDS(FRAME_WORDS),
    .FRAMES     (FRAMES)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .dpCtrl(dpCtrl),
    .wrData(wrData),
    .rdData(rdData),
    .wrPtr (wrPtr),
    .rdPtr (rdPtr)
  );
endmodule

// File: tb/frame_slip_buffer_bench.sv
`timescale 1ns/1ps
module frame_slip_buffer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameLocked = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       skipClr = 1'b0;
  logic       maskWe = 1'b0;
  logic       maskIn = 1'b1;
  logic       skipFlag;
  logic       slowLocal;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  frame_slip_buffer u_frame_slip_buffer (
    .clk(clk), .rstN(rstN), .frameLocked(frameLocked),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .skipClr(skipClr), .maskWe(maskWe), .maskIn(maskIn),
    .skipFlag(skipFlag), .slowLocal(slowLocal), .irq(irq)
  );

  task automatic check(input int actual, input int expected, input string tag);
    vectors++;
    if (actual != expected) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 0; rdEn = 0; skipClr = 0; maskWe = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pushWords(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wrEn = 1'b1; wrData = 8'(base + i);
      @(negedge clk);
    end
    wrEn = 1'b0;
  endtask

  task automatic readSeq(input int n, input int first, input string tag);
    for (int i = 0; i < n; i++) begin
      rdEn = 1'b1;
      @(negedge clk);
      rdEn = 1'b0;
      check(int'(rdData), first + i, tag);
      @(negedge clk);
    end
  endtask

  task automatic setMask(input logic v);
    maskWe = 1'b1; maskIn = v;
    @(negedge clk);
    maskWe = 1'b0;
  endtask

  task automatic pulseClr();
    skipClr = 1'b1;
    @(negedge clk);
    skipClr = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check(int'(rdData), 0, "R1 rdData");
    check(int'(skipFlag), 0, "R1 skipFlag");
    check(int'(slowLocal), 0, "R1 slowLocal");
    check(int'(irq), 0, "R1 irq");
  endtask

  task automatic testInOrder();
    doReset();
    frameLocked = 1'b1;
    pushWords(40, 0);
    // R3: fill 8 at boundary 32, then 7..4 off boundary: no slip
    readSeq(36, 0, "R2 R3 in-order");
    check(int'(skipFlag), 0, "R3 no slip flag");
  endtask

  task automatic testDropEdge();
    doReset();
    frameLocked = 1'b1;
    pushWords(56, 10);
    readSeq(1, 10, "R3 fill 56 no drop");
    check(int'(skipFlag), 0, "R3 fill 56 flag");
  endtask

  task automatic testRepeat();
    doReset();
    frameLocked = 1'b1;
    pushWords(36, 0);
    readSeq(32, 0, "R2 first frame");
    readSeq(32, 0, "R5 repeated frame");
    check(int'(skipFlag), 1, "R6 skip after repeat");
    check(int'(slowLocal), 0, "R8 slowLocal after repeat");
    check(int'(irq), 0, "R9 masked out of reset");
    setMask(1'b0);
    check(int'(irq), 1, "R9 irq unmasked");
    pulseClr();
    check(int'(skipFlag), 0, "R7 cleared");
    check(int'(irq), 0, "R7 irq after clear");
  endtask

  task automatic testDrop();
    doReset();
    frameLocked = 1'b1;
    pushWords(60, 0);
    readSeq(4, 32, "R4 dropped frame");
    check(int'(skipFlag), 1, "R6 skip after drop");
    check(int'(slowLocal), 1, "R8 slowLocal after drop");
    setMask(1'b0);
    check(int'(irq), 1, "R9 irq after drop");
  endtask

  task automatic testUnlocked();
    doReset();
    frameLocked = 1'b0;
    pushWords(57, 100);
    readSeq(1, 132, "R4 drop at fill 57");
    check(int'(slowLocal), 1, "R8 slowLocal unlocked");
    check(int'(skipFlag), 0, "R6 no skip unlocked");
    setMask(1'b0);
    check(int'(irq), 0, "R8 irq not from slowLocal");
  endtask

  initial begin
    #(200000 * 10);
    miscompares++;
    $display("FAIL watchdog expired (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    testReset();
    testInOrder();
    testDropEdge();
    testRepeat();
    testDrop();
    testUnlocked();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule